// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a small synchronous static memory with a word of four 9-bit byte lanes (36 bits) and a depth set by an address-width parameter. Address, write data, the three chip-select inputs and every write control are sampled on the rising clock edge into an input stage. The array access then takes place on the following edge. Read data leaves through its own output register, so a read returns its data two rising edges after it was presented.

The chip selects are taken in only in a cycle where one of the two address strobes is low. In other cycles the selection from the last strobe stays in force, and a companion burst block can keep supplying new addresses. A write either covers the whole word (global write) or a chosen subset of lanes (byte-write enable with one control per lane). The output drive enable has a pipeline of its own. After a read, a deselect keeps the drivers on for one more cycle, so memories placed side by side can hand the bus over without a dead cycle. The output is a value plus a drive-enable. Output enable gates the drive-enable combinationally.

A sleep input freezes every register and blocks writes while it is high. It also turns the drive-enable off at once, and the stored contents are kept.

Top module: `bw_sync_sram`

## Requirements
- R1: While reset is low, and in the cycle after it, `dout_en` is 0 and `dout` is 0. Stored data is not cleared by reset.
- R2: A read presented before rising edge E0 (selected, no lane enabled) shows the word on `dout` with `dout_en`=1 after edge E1.
- R3: With `gw_n`=0, all four lanes are written whatever the values of `bwe_n` and `bw_n`.
- R4: With `gw_n`=1 and `bwe_n`=0, lane i (bits 9i+8..9i) is written exactly when `bw_n[i]`=0. The other lanes keep their old contents.
- R5: With `gw_n`=1 and `bwe_n`=1, no lane is written, and the cycle acts as a read.
- R6: The selection (`cs1_n`=0, `cs2`=1, `cs3_n`=0) is sampled only when `ads_cpu_n` or `ads_ctl_n` is 0. With both strobes high, the previous selection is kept. A deselected cycle neither writes nor reads.
- R7: After a read, if the next operation is a deselect, `dout_en` stays 1 for one extra cycle and then goes to 0.
- R8: A write operation turns `dout_en` off after the edge on which the array is written.
- R9: `oe_n`=1 forces `dout_en` to 0 without waiting for a clock edge. `oe_n`=0 restores it.
- R10: While `sleep` is 1, `dout_en` is 0 at once, no write takes place and all registered state holds. Data written before sleep survives it.
- R11: A read of an address presented in the cycle right after a write to it returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled every edge |
| din | input | 36 | Write data, sampled every edge |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ads_cpu_n | input | 1 | Address strobe from the processor side, active low |
| ads_ctl_n | input | 1 | Address strobe from the controller side, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane byte-write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Suspend operation, active high |
| dout | output | 36 | Registered read data |
| dout_en | output | 1 | Output drive enable |

## Verification
A wrong lane mask shows up as a corrupted or stale lane at the next readback of that address, two edges after the read is presented. A stuck or mis-held selection register shows up as a read that never drives, or as a write that lands while the chip is deselected; the following readback exposes it. A fault in the drive pipeline shows up within one or two cycles as `dout_en` missing its extra deselect cycle, staying on across a write, or staying on after the extra cycle. Sleep faults show up at once on `dout_en`, or later as a changed word after wake-up.

// File: rtl/pl_sram_pkg.sv
// Shared types for the pipelined byte-lane SRAM.
package pl_sram_pkg;
    // Operation carried by the registered input stage
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/pl_sram_wdec.sv
// Write-control decode: turns global write, byte-write enable and the
// per-lane selects into one write flag per lane.
// Assumes active-low controls; global write overrides everything else.
module pl_sram_wdec #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);
    // One decode term per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !gw_n || (!bwe_n && !bw_n[g]);
    end
endmodule

// File: rtl/pl_sram_ctrl.sv
// Input stage: registers address, data and the lane mask every edge,
// and registers the chip selection only on a strobe cycle.
// Assumes run is low during sleep, which freezes the stage.
module pl_sram_ctrl
    import pl_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     din,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              ads_cpu_n,
    input  logic              ads_ctl_n,
    input  logic [LANES-1:0]  lane_we,
    output op_e               op,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DW-1:0]     din_q,
    output logic [LANES-1:0]  lane_q
);
    logic sel_q;
    logic strobe;
    logic cs_ok;

    assign strobe = !ads_cpu_n || !ads_ctl_n;
    assign cs_ok  = !cs1_n && cs2 && !cs3_n;

    // Capture the request; selection only moves on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            addr_q <= '0;
            din_q  <= '0;
            lane_q <= '0;
        end else if (run) begin
            addr_q <= addr;
            din_q  <= din;
            lane_q <= lane_we;
            if (strobe) begin
                sel_q <= cs_ok;
            end
        end
    end

    // Classify the registered request
    always_comb begin
        op = OP_IDLE;
        if (sel_q) begin
            op = (|lane_q) ? OP_WRITE : OP_READ;
        end
    end

    // R6
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe) |=> $stable(sel_q));
endmodule

// File: rtl/pl_sram_array.sv
// Storage split into byte lanes, with a registered read port.
// Assumes op, addr_q, din_q and lane_q come from the input stage;
// contents are not reset, only the output register is.
module pl_sram_array
    import pl_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DW-1:0]     din_q,
    input  logic [LANES-1:0]  lane_q,
    output logic [DW-1:0]     rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write, only when awake and this lane is selected
        always_ff @(posedge clk) begin
            if (run && op == OP_WRITE && lane_q[g]) begin
                mem[addr_q] <= din_q[g*LANE_W +: LANE_W];
            end
        end

        // Output register for this lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (run && op == OP_READ) begin
                rdata[g*LANE_W +: LANE_W] <= mem[addr_q];
            end
        end
    end

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> $stable(rdata));
endmodule

// File: rtl/pl_sram_drv.sv
// Output drive pipeline with double-cycle deselect: after a read, a
// deselect keeps the drivers on for one more cycle. Output enable and
// sleep gate the result combinationally.
module pl_sram_drv
    import pl_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  op_e  op,
    input  logic oe_n,
    output logic dout_en
);
    logic rd_prev_q;
    logic drv_q;
    logic rd_now;

    assign rd_now = (op == OP_READ);

    // Track the last read and extend drive over one deselect cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev_q <= 1'b0;
            drv_q     <= 1'b0;
        end else if (run) begin
            rd_prev_q <= rd_now;
            drv_q     <= rd_now || (rd_prev_q && op == OP_IDLE);
        end
    end

    // Asynchronous gating by output enable and sleep
    assign dout_en = drv_q && !oe_n && run;

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !drv_q);
    // R7
    hold_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && drv_q && !rd_prev_q && op != OP_READ) |=> !drv_q);
    // R8
    write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && op == OP_WRITE) |=> !drv_q);
endmodule

// File: rtl/bw_sync_sram.sv
// Top level of the pipelined byte-lane SRAM: write decode, input stage,
// lane storage with registered output, and the drive-enable pipeline.
// Assumes sleep may change at any time; it only acts on the clocked
// state as a hold, so an asynchronous assertion cannot cause a write.
module bw_sync_sram
    import pl_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     din,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              ads_cpu_n,
    input  logic              ads_ctl_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DW-1:0]     dout,
    output logic              dout_en
);
    logic              run;
    logic [LANES-1:0]  lane_we;
    logic [LANES-1:0]  lane_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     din_q;
    op_e               op;

    assign run = !sleep;

    pl_sram_wdec #(.LANES(LANES)) u_wdec (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we)
    );

    pl_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .addr      (addr),
        .din       (din),
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .cs3_n     (cs3_n),
        .ads_cpu_n (ads_cpu_n),
        .ads_ctl_n (ads_ctl_n),
        .lane_we   (lane_we),
        .op        (op),
        .addr_q    (addr_q),
        .din_q     (din_q),
        .lane_q    (lane_q)
    );

    pl_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .op     (op),
        .addr_q (addr_q),
        .din_q  (din_q),
        .lane_q (lane_q),
        .rdata  (dout)
    );

    pl_sram_drv u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .op      (op),
        .oe_n    (oe_n),
        .dout_en (dout_en)
    );
endmodule

// File: tb/bw_sync_sram_tb.sv
module bw_sync_sram_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [35:0] din = '0;
    logic        cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic        ads_cpu_n = 1'b1, ads_ctl_n = 1'b1;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic        oe_n = 1'b0, sleep = 1'b0;
    logic [35:0] dout;
    logic        dout_en;

    int errors = 0;
    int checks = 0;

    always #(CLK_P/2) clk = ~clk;

    bw_sync_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  a;
        logic [35:0] d;
        logic        gwn;
        logic        bwen;
        logic [3:0]  bwn;
        logic [35:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{1'b1, 4'd1, 36'h123456789, 1'b0, 1'b1, 4'hF, 36'h0},          // R3 full word
        '{1'b0, 4'd1, 36'h0,         1'b1, 1'b1, 4'hF, 36'h123456789},  // R2 read
        '{1'b1, 4'd2, 36'hAAAAAAAAA, 1'b0, 1'b1, 4'hF, 36'h0},          // R3
        '{1'b1, 4'd2, 36'h0,         1'b1, 1'b0, 4'b1110, 36'h0},       // R4 lane 0 only
        '{1'b0, 4'd2, 36'h0,         1'b1, 1'b1, 4'hF, 36'hAAAAAAA00},  // R4 readback
        '{1'b1, 4'd2, 36'h0,         1'b1, 1'b1, 4'h0, 36'h0},          // R5 no write
        '{1'b0, 4'd2, 36'h0,         1'b1, 1'b1, 4'hF, 36'hAAAAAAA00},  // R5 readback
        '{1'b1, 4'd3, 36'hFFFFFFFFF, 1'b0, 1'b1, 4'hF, 36'h0},          // R3 gw overrides
        '{1'b1, 4'd3, 36'h0,         1'b1, 1'b0, 4'b0101, 36'h0},       // R4 lanes 1,3
        '{1'b0, 4'd3, 36'h0,         1'b1, 1'b1, 4'hF, 36'h007FC01FF}   // R4 readback
    };

    task automatic chk(input bit ok, input string msg,
                       input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", msg, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input bit strobe, input bit sel, input logic [3:0] a,
                       input logic [35:0] d, input logic g, input logic be,
                       input logic [3:0] b);
        ads_ctl_n = !strobe;
        ads_cpu_n = 1'b1;
        cs1_n = !sel; cs2 = sel; cs3_n = !sel;
        addr = a; din = d; gw_n = g; bwe_n = be; bw_n = b;
    endtask

    task automatic rd(input logic [3:0] a);
        put(1'b1, 1'b1, a, 36'h0, 1'b1, 1'b1, 4'hF);
    endtask

    task automatic idle();
        put(1'b1, 1'b0, 4'h0, 36'h0, 1'b1, 1'b1, 4'hF);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk(dout_en == 1'b0, "R1 drive in reset", {35'h0, dout_en}, 36'h0);
        rst_n = 1'b1;
        step();
        chk(dout_en == 1'b0, "R1 drive after reset", {35'h0, dout_en}, 36'h0);
        chk(dout == 36'h0, "R1 data after reset", dout, 36'h0);

        // Table walk: each entry, then three deselect cycles
        for (int i = 0; i < NV; i++) begin
            put(1'b1, 1'b1, VT[i].a, VT[i].d, VT[i].gwn, VT[i].bwen, VT[i].bwn);
            step();
            idle();
            step();
            if (!VT[i].wr) begin
                chk(dout == VT[i].exp, "R2 table read data", dout, VT[i].exp);
                chk(dout_en == 1'b1, "R2 table read drive", {35'h0, dout_en}, 36'h1);
            end
            step();
            if (!VT[i].wr)
                chk(dout_en == 1'b1, "R7 extra deselect cycle", {35'h0, dout_en}, 36'h1);
            step();
            chk(dout_en == 1'b0, "R7 drive off after extension", {35'h0, dout_en}, 36'h0);
        end

        // R8 / R11: read, write, read same address back to back
        rd(4'd1);
        step();
        put(1'b1, 1'b1, 4'd5, 36'h5A5A5A5A5, 1'b0, 1'b1, 4'hF);
        step();
        chk(dout_en == 1'b1 && dout == 36'h123456789, "R8 read before write", dout, 36'h123456789);
        rd(4'd5);
        step();
        chk(dout_en == 1'b0, "R8 write turns drive off", {35'h0, dout_en}, 36'h0);
        idle();
        step();
        chk(dout == 36'h5A5A5A5A5, "R11 read after write", dout, 36'h5A5A5A5A5);
        chk(dout_en == 1'b1, "R11 drive", {35'h0, dout_en}, 36'h1);
        step(); step();

        // R6: selection held without strobe
        rd(4'd1);
        step();
        put(1'b0, 1'b0, 4'd2, 36'h0, 1'b1, 1'b1, 4'hF);
        step();
        idle();
        step();
        chk(dout == 36'hAAAAAAA00 && dout_en, "R6 selection held", dout, 36'hAAAAAAA00);
        step(); step();
        // deselected: write without strobe, then strobed write with cs2 low
        put(1'b0, 1'b1, 4'd1, 36'h0, 1'b0, 1'b1, 4'hF);
        step();
        idle();
        step();
        put(1'b1, 1'b1, 4'd1, 36'h0, 1'b0, 1'b1, 4'hF);
        cs2 = 1'b0;
        step();
        chk(dout_en == 1'b0, "R6 deselected no drive", {35'h0, dout_en}, 36'h0);
        idle();
        step();
        rd(4'd1);
        step();
        idle();
        step();
        chk(dout == 36'h123456789, "R6 deselected write ignored", dout, 36'h123456789);
        step(); step();

        // R9: asynchronous output enable
        rd(4'd1);
        step();
        idle();
        step();
        oe_n = 1'b1;
        #1;
        chk(dout_en == 1'b0, "R9 oe_n high", {35'h0, dout_en}, 36'h0);
        oe_n = 1'b0;
        #1;
        chk(dout_en == 1'b1, "R9 oe_n low", {35'h0, dout_en}, 36'h1);
        step(); step();

        // R10: sleep
        rd(4'd3);
        step();
        idle();
        step();
        #1 sleep = 1'b1;
        #1;
        chk(dout_en == 1'b0, "R10 sleep drive off", {35'h0, dout_en}, 36'h0);
        put(1'b1, 1'b1, 4'd3, 36'h0, 1'b0, 1'b1, 4'hF);
        step(); step(); step();
        chk(dout == 36'h007FC01FF, "R10 output held", dout, 36'h007FC01FF);
        idle();
        sleep = 1'b0;
        #1;
        chk(dout_en == 1'b1, "R10 drive back after sleep", {35'h0, dout_en}, 36'h1);
        step(); step();
        rd(4'd3);
        step();
        idle();
        step();
        chk(dout == 36'h007FC01FF, "R10 data survives sleep", dout, 36'h007FC01FF);
        step(); step();

        // R1: reset during activity
        rd(4'd1);
        step();
        rst_n = 1'b0;
        idle();
        step();
        chk(dout_en == 1'b0 && dout == 36'h0, "R1 reset mid-read", dout, 36'h0);
        rst_n = 1'b1;
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule